// File: doc/BRIEF.md
# Prioritized Interrupt Aggregator with Fetch-Stream Vector Insertion

Fourteen interrupt sources share one CPU interrupt line. Each source raises a sticky pending bit with a one-cycle request pulse. The pending bit stays set until software clears it with a write-one-to-clear strobe. A fixed-priority encoder picks the most urgent pending source and forms an 8-bit vector byte for it. The vector steps by four from a base value of 0x80.

When autovectoring is on, the block watches the CPU's code-fetch address. The CPU enters the shared handler at code address 0x0053, which holds a jump instruction. The byte at 0x0054 is the high byte of a jump table and comes from memory unchanged. The byte fetched from 0x0055 is replaced by the vector byte, so the jump lands on the handler entry for the winning source.

The vector is frozen at the moment the fetch reaches the entry address. It stays frozen for the rest of the three-byte jump, so a late, more urgent request cannot alter a dispatch that has already started.

Top module: `irq_vector_mux`

## Requirements
- R1: While reset is asserted and on leaving it, no bit is pending, `irq_o` is 0 and `vec_o` is 0x80.
- R2: A 1 on `src_req_i[k]` at a clock edge sets pending bit k. The bit stays set on later cycles with no request.
- R3: A 1 on `src_clr_i[k]` at a clock edge clears pending bit k. If the request and the clear for the same bit are both 1 in one cycle, the bit ends up set.
- R4: `irq_o` is 1 exactly when `glb_en_i` is 1 and at least one bit is pending. Dropping `glb_en_i` does not discard pending bits.
- R5: Bit 0 has the highest priority and bit 13 the lowest. Outside a dispatch, `vec_o` equals 0x80 + 4×k, where k is the lowest-numbered pending bit.
- R6: Outside a dispatch with nothing pending, `vec_o` is 0x80.
- R7: With `av_en_i` = 1, a fetch at address 0x0055 returns `vec_o` on `fetch_data_o`. Fetches at any other address, including 0x0053 and 0x0054, return `mem_data_i`.
- R8: With `av_en_i` = 0, `fetch_data_o` equals `mem_data_i` at every address, including 0x0055.
- R9: A clock edge with `fetch_addr_i` = 0x0053 captures the current vector and starts a dispatch. The capture happens only if no dispatch is already under way.
- R10: During a dispatch, `vec_o` holds the captured value, whatever requests arrive. The dispatch ends at the first clock edge where `fetch_addr_i` lies outside 0x0053..0x0055.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_req_i | input | 14 | Per-source request pulses, bit 0 highest priority |
| src_clr_i | input | 14 | Per-source write-one-to-clear strobes |
| glb_en_i | input | 1 | Global enable for the shared interrupt line |
| av_en_i | input | 1 | Autovector enable |
| fetch_addr_i | input | 16 | CPU code-fetch address |
| mem_data_i | input | 8 | Byte read from code memory |
| irq_o | output | 1 | Shared interrupt request |
| vec_o | output | 8 | Current or captured vector byte |
| fetch_data_o | output | 8 | Byte returned to the CPU fetch |

## Verification
The assertions take for granted that the fetch address is stable across each clock cycle. They also assume a dispatch walks 0x0053, 0x0054, 0x0055 and then leaves that window, with no jump back to 0x0053 partway through. The stimulus changes all inputs only between edges. It always steps the address through the three entry bytes in order before moving elsewhere. It injects the more urgent request in the middle of that walk, so the frozen vector is the value under test.

// File: rtl/irq_vector_mux.sv
module irq_vector_mux #(
  parameter int NSRC = 14,
  parameter int AW = 16,
  parameter int DW = 8,
  parameter logic [AW-1:0] ENTRY_ADDR = 16'h0053,
  parameter logic [DW-1:0] VEC_BASE = 8'h80,
  parameter int VEC_STEP = 4
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src_req_i,
  input  logic [NSRC-1:0] src_clr_i,
  input  logic            glb_en_i,
  input  logic            av_en_i,
  input  logic [AW-1:0]   fetch_addr_i,
  input  logic [DW-1:0]   mem_data_i,
  output logic            irq_o,
  output logic [DW-1:0]   vec_o,
  output logic [DW-1:0]   fetch_data_o
);

  localparam int IW = $clog2(NSRC);
  localparam logic [AW-1:0] VEC_ADDR = ENTRY_ADDR + AW'(2);
  localparam int VEC_TOP = int'(VEC_BASE) + (NSRC - 1) * VEC_STEP;

  logic [NSRC-1:0] pending;
  logic [IW-1:0]   win_idx;
  logic [DW-1:0]   live_vec;
  logic [DW-1:0]   hold_vec;
  logic            lock_q;
  logic            in_window;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) pending <= '0;
    else        pending <= (pending & ~src_clr_i) | src_req_i;

  always_comb begin
    win_idx = '0;
    for (int i = NSRC - 1; i >= 0; i--)
      if (pending[i]) win_idx = IW'(i);
  end

  assign live_vec  = VEC_BASE + DW'(win_idx) * DW'(VEC_STEP);
  assign in_window = (fetch_addr_i >= ENTRY_ADDR) && (fetch_addr_i <= VEC_ADDR);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      lock_q   <= 1'b0;
      hold_vec <= VEC_BASE;
    end else if (!lock_q && fetch_addr_i == ENTRY_ADDR) begin
      lock_q   <= 1'b1;
      hold_vec <= live_vec;
    end else if (lock_q && !in_window) begin
      lock_q   <= 1'b0;
    end

  assign irq_o        = glb_en_i & (|pending);
  assign vec_o        = lock_q ? hold_vec : live_vec;
  assign fetch_data_o = (av_en_i && fetch_addr_i == VEC_ADDR) ? vec_o : mem_data_i;

  // R2
  req_sets_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (src_req_i != '0) |=> ((pending & $past(src_req_i)) == $past(src_req_i)));

  // R3
  clr_drops_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((src_clr_i & ~src_req_i) != '0) |=> ((pending & $past(src_clr_i & ~src_req_i)) == '0));

  // R5
  vec_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(vec_o) >= int'(VEC_BASE)) && (int'(vec_o) <= VEC_TOP) &&
    (((int'(vec_o) - int'(VEC_BASE)) % VEC_STEP) == 0));

  // R10
  frozen_in_dispatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_q && in_window) |=> $stable(vec_o));

  // R6
  idle_vec_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_q && pending == '0) |-> (vec_o == VEC_BASE));

endmodule

// File: tb/irq_vector_mux_bench.sv
module irq_vector_mux_bench;
  localparam int CLK_PERIOD = 10;

  typedef struct {
    string      tag;
    logic       irq;
    logic [7:0] vec;
    logic [7:0] fd;
  } exp_t;

  logic clk = 0, rst_n = 0;
  logic [13:0] src_req = '0, src_clr = '0;
  logic glb_en = 1, av_en = 0;
  logic [15:0] addr = 16'h0100;
  logic [7:0] mem = 8'h5A;
  logic irq;
  logic [7:0] vec, fdata;

  exp_t q[$];
  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_vector_mux u_irq_vector_mux (
    .clk(clk), .rst_n(rst_n), .src_req_i(src_req), .src_clr_i(src_clr),
    .glb_en_i(glb_en), .av_en_i(av_en), .fetch_addr_i(addr), .mem_data_i(mem),
    .irq_o(irq), .vec_o(vec), .fetch_data_o(fdata));

  task automatic step(input string tag, input logic [13:0] r, input logic [13:0] c,
                      input logic [15:0] a, input logic [7:0] m,
                      input logic ei, input logic [7:0] ev, input logic [7:0] ef);
    exp_t e;
    @(negedge clk);
    src_req = r; src_clr = c; addr = a; mem = m;
    @(posedge clk);
    #1;
    e.tag = tag; e.irq = ei; e.vec = ev; e.fd = ef;
    q.push_back(e);
  endtask

  initial forever begin
    @(posedge clk);
    #2;
    while (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (irq !== e.irq || vec !== e.vec || fdata !== e.fd) begin
        errors++;
        $display("FAIL %s: got irq=%0b vec=%02h fd=%02h exp irq=%0b vec=%02h fd=%02h",
                 e.tag, irq, vec, fdata, e.irq, e.vec, e.fd);
      end
    end
  end

  initial begin
    #(CLK_PERIOD * 5000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step("R1 in reset", '0, '0, 16'h0100, 8'h5A, 0, 8'h80, 8'h5A);
    @(negedge clk); rst_n = 1;
    step("R1 after reset", '0, '0, 16'h0100, 8'h5A, 0, 8'h80, 8'h5A);
    step("R2 R5 src14", 14'h2000, '0, 16'h0100, 8'h5A, 1, 8'hB4, 8'h5A);
    step("R2 sticky", '0, '0, 16'h0100, 8'h5A, 1, 8'hB4, 8'h5A);
    step("R5 src5 wins", 14'h0010, '0, 16'h0100, 8'h5A, 1, 8'h90, 8'h5A);
    step("R5 src1 wins", 14'h0001, '0, 16'h0100, 8'h5A, 1, 8'h80, 8'h5A);
    step("R3 clear src1", '0, 14'h0001, 16'h0100, 8'h5A, 1, 8'h90, 8'h5A);
    step("R3 set wins", 14'h0010, 14'h0010, 16'h0100, 8'h5A, 1, 8'h90, 8'h5A);
    step("R3 clear src5", '0, 14'h0010, 16'h0100, 8'h5A, 1, 8'hB4, 8'h5A);
    @(negedge clk); glb_en = 0;
    step("R4 masked", '0, '0, 16'h0100, 8'h5A, 0, 8'hB4, 8'h5A);
    @(negedge clk); glb_en = 1;
    step("R4 unmasked keeps pending", '0, '0, 16'h0100, 8'h5A, 1, 8'hB4, 8'h5A);
    @(negedge clk); av_en = 1;
    step("R9 R7 entry byte", '0, '0, 16'h0053, 8'h02, 1, 8'hB4, 8'h02);
    step("R10 R7 page byte, src2 arrives", 14'h0002, '0, 16'h0054, 8'h10, 1, 8'hB4, 8'h10);
    step("R10 R7 vector byte frozen", '0, '0, 16'h0055, 8'h33, 1, 8'hB4, 8'hB4);
    step("R10 release", '0, '0, 16'h0100, 8'h5A, 1, 8'h84, 8'h5A);
    @(negedge clk); av_en = 0;
    step("R8 passthrough", '0, '0, 16'h0055, 8'h77, 1, 8'h84, 8'h77);
    step("R6 all cleared", '0, 14'h3FFF, 16'h0100, 8'h5A, 0, 8'h80, 8'h5A);
    @(negedge clk); av_en = 1;
    step("R6 R7 idle vector fetch", '0, '0, 16'h0055, 8'h11, 0, 8'h80, 8'h80);
    for (int k = 0; k < 14; k++)
      step($sformatf("R5 R3 sweep src%0d", k + 1), 14'(1) << k, 14'h3FFF,
           16'h0100, 8'h5A, 1, 8'(8'h80 + 4 * k), 8'h5A);
    step("R9 second dispatch entry", '0, '0, 16'h0053, 8'h02, 1, 8'hB4, 8'h02);
    step("R10 src1 arrives mid-dispatch", 14'h0001, '0, 16'h0054, 8'h20, 1, 8'hB4, 8'h20);
    step("R10 R7 vector stays src14", '0, '0, 16'h0055, 8'h44, 1, 8'hB4, 8'hB4);
    step("R10 R5 release to src1", '0, '0, 16'h0200, 8'h5A, 1, 8'h80, 8'h5A);
    @(negedge clk);
    @(negedge clk);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule